// File: doc/BRIEF.md
# UART Receive Event Flag Unit

This block collects the receive-side events of a UART and turns them into four sticky status flags and a single interrupt request. It counts characters from the start of a block and signals end of block once the programmed payload length plus four prologue characters has arrived. It also times line idleness in bit periods after each reception, reports the resynchronised level of the active-low clear-to-send input together with a flag for any change on it, and latches a line-break indication that an external detector delivers as a pulse.

Software clears the flags by writing ones to a separate clear register. A zero in that write leaves its flag alone. Each flag contributes to the interrupt only while its enable bit is high. The serial shifter, the baud generator, the break detector and the register decoder are outside the block. The block connects to them through strobes and plain level inputs.

Top module: `uart_rx_evt_flags`

## Requirements
- R1: After synchronous reset, with `cts_n_i` high, the outputs `flags_o`, `irq_o`, `busy_o` and `cts_lvl_o` are all 0.
- R2: Flag bit 0 (end of block) is set at the clock edge of a `byte_i` strobe whose updated count is at least `blk_len_i` + 4. The count is the number of strobes since the last `blk_start_i`. A `blk_start_i` zeroes the count, and it wins over a strobe in the same cycle, which is then not counted.
- R3: The block count saturates at 2^CNT_W-1 and does not wrap. With the defaults and `blk_len_i`=255, every strobe after 1100 strobes still sets flag bit 0.
- R4: Flag bit 1 (receive timeout) is set at the edge of the `to_val_i`-th `tick_i` that follows the last reception, where a reception is a `byte_i` or `start_i` pulse. A reception reloads the count and wins over a tick in the same cycle. After the flag sets, the counter stops until the next reception, and no counting happens before the first reception after reset.
- R5: `cts_lvl_o` is the inverse of `cts_n_i` after a two-flop synchroniser, so it follows the pin two clock edges later.
- R6: Flag bit 2 (CTS change) is set three clock edges after `cts_n_i` toggles in either direction.
- R7: Flag bit 3 (break) is set at the clock edge on which `brk_i` is high.
- R8: With `clr_we_i` high, each 1 in `clr_i` clears the flag at the same bit position at that edge. Each 0 in `clr_i` leaves its flag unchanged.
- R9: When a set event and a clear of the same flag happen in the same cycle, the flag ends up set.
- R10: `irq_o` equals the OR of (`flags_o` AND `irq_en_i`) as it stood one cycle earlier.
- R11: `busy_o` equals `rx_busy_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_busy_i | input | 1 | Receive path active level |
| byte_i | input | 1 | One-cycle strobe per received character |
| start_i | input | 1 | One-cycle strobe per detected start bit |
| blk_start_i | input | 1 | Pulse that begins a new block count |
| blk_len_i | input | LEN_W | Programmed block payload length |
| tick_i | input | 1 | One-cycle bit-period tick |
| to_val_i | input | TO_W | Idle timeout in bit periods |
| cts_n_i | input | 1 | Asynchronous active-low clear-to-send |
| brk_i | input | 1 | Break detected pulse |
| clr_we_i | input | 1 | Clear register write strobe |
| clr_i | input | 4 | Write-one-to-clear data, bit order as flags |
| irq_en_i | input | 4 | Per-flag interrupt enables |
| flags_o | output | 4 | Sticky flags: 0 end of block, 1 timeout, 2 CTS change, 3 break |
| cts_lvl_o | output | 1 | Inverted synchronised CTS level |
| busy_o | output | 1 | Registered receive-busy status |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Flags from the block counter, the timeout counter, the break pulse and the clear write are due one edge after their stimulus. The CTS level is due two edges after a pin change and the change flag three edges after it. `irq_o` and `busy_o` trail their sources by one edge. The bench drives inputs on falling edges. A reference model advances on every rising edge, and every output is compared on the following falling edge, so each result is sampled in exactly the cycle it becomes due. The directed cases check the exact threshold, a simultaneous set and clear, counter saturation and one-shot timeout against the same sampling point.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FLG_EOB   = 0;
  localparam int FLG_RTO   = 1;
  localparam int FLG_CTSC  = 2;
  localparam int FLG_BRK   = 3;
endpackage

// File: rtl/uart_evt_blkcnt.sv
module uart_evt_blkcnt #(
  parameter int CNT_W = 10,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_start_i,
  input  logic             byte_i,
  input  logic [LEN_W-1:0] blk_len_i,
  output logic             eob_evt_o
);
  localparam int CW = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 2;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CW-1:0]    thr;
  logic [CW-1:0]    nxt_ext;

  assign cnt_nxt = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
  assign thr     = {{(CW-LEN_W){1'b0}}, blk_len_i} + CW'(4);
  assign nxt_ext = {{(CW-CNT_W){1'b0}}, cnt_nxt};

  // prologue of four characters counts toward the block end
  assign eob_evt_o = byte_i && !blk_start_i && (nxt_ext >= thr);

  always_ff @(posedge clk) begin
    if (rst || blk_start_i) begin
      cnt_q <= '0;
    end else if (byte_i) begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/uart_evt_timeout.sv
module uart_evt_timeout #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_evt_i,
  input  logic            tick_i,
  input  logic [TO_W-1:0] to_val_i,
  output logic            to_evt_o
);
  logic [TO_W-1:0] cnt_q;
  logic            armed_q;
  logic [TO_W:0]   inc;
  logic            hit;

  assign inc      = {1'b0, cnt_q} + 1'b1;
  assign hit      = inc >= {1'b0, to_val_i};
  assign to_evt_o = !rx_evt_i && tick_i && armed_q && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (rx_evt_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (tick_i && armed_q) begin
      if (hit) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        cnt_q <= inc[TO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/uart_evt_ctssync.sv
module uart_evt_ctssync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_n_i,
  output logic cts_lvl_o,
  output logic cts_chg_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cts_lvl_o = !sync_q[SYNC_STAGES-1];
  assign cts_chg_o = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/uart_evt_flagbank.sv
module uart_evt_flagbank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;
  logic         irq_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) begin
          flags_q[g] <= 1'b0;
        end else if (set_i[g]) begin
          flags_q[g] <= 1'b1;
        end else if (clr_we_i && clr_i[g]) begin
          flags_q[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags_q & en_i);
  end

  assign flags_o = flags_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/uart_rx_evt_flags.sv
module uart_rx_evt_flags
  import uart_evt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int LEN_W = 8,
  parameter int TO_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_busy_i,
  input  logic                 byte_i,
  input  logic                 start_i,
  input  logic                 blk_start_i,
  input  logic [LEN_W-1:0]     blk_len_i,
  input  logic                 tick_i,
  input  logic [TO_W-1:0]      to_val_i,
  input  logic                 cts_n_i,
  input  logic                 brk_i,
  input  logic                 clr_we_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  input  logic [NUM_FLAGS-1:0] irq_en_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 cts_lvl_o,
  output logic                 busy_o,
  output logic                 irq_o
);
  logic                 eob_evt;
  logic                 to_evt;
  logic                 cts_chg;
  logic [NUM_FLAGS-1:0] set_vec;
  logic                 busy_q;

  uart_evt_blkcnt #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_blkcnt (
    .clk(clk), .rst(rst), .blk_start_i(blk_start_i), .byte_i(byte_i),
    .blk_len_i(blk_len_i), .eob_evt_o(eob_evt)
  );

  uart_evt_timeout #(.TO_W(TO_W)) u_timeout (
    .clk(clk), .rst(rst), .rx_evt_i(byte_i || start_i), .tick_i(tick_i),
    .to_val_i(to_val_i), .to_evt_o(to_evt)
  );

  uart_evt_ctssync #(.SYNC_STAGES(2)) u_cts (
    .clk(clk), .rst(rst), .cts_n_i(cts_n_i), .cts_lvl_o(cts_lvl_o),
    .cts_chg_o(cts_chg)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_EOB]  = eob_evt;
    set_vec[FLG_RTO]  = to_evt;
    set_vec[FLG_CTSC] = cts_chg;
    set_vec[FLG_BRK]  = brk_i;
  end

  uart_evt_flagbank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_we_i(clr_we_i), .clr_i(clr_i),
    .en_i(irq_en_i), .flags_o(flags_o), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= rx_busy_i;
  end
  assign busy_o = busy_q;
endmodule

// File: rtl/uart_rx_evt_flags_chk.sv
module uart_rx_evt_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_busy_i,
  input logic       brk_i,
  input logic       clr_we_i,
  input logic [3:0] clr_i,
  input logic [3:0] irq_en_i,
  input logic [3:0] flags_o,
  input logic       busy_o,
  input logic       irq_o
);
  logic [3:0] clr_mask;
  assign clr_mask = clr_we_i ? clr_i : 4'b0000;

  AST_BRK_SETS: assert property (@(posedge clk) disable iff (rst)
    brk_i |=> flags_o[3]); // R7
  AST_CLR_ONE: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && clr_i[3] && !brk_i) |=> !flags_o[3]); // R8
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flags_o) & ~$past(clr_mask) & ~flags_o) == 4'b0000)); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (brk_i && clr_we_i && clr_i[3]) |=> flags_o[3]); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |($past(flags_o & irq_en_i)))); // R10
  AST_BUSY_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (busy_o == $past(rx_busy_i))); // R11
endmodule

bind uart_rx_evt_flags uart_rx_evt_flags_chk u_chk (
  .clk(clk), .rst(rst), .rx_busy_i(rx_busy_i), .brk_i(brk_i),
  .clr_we_i(clr_we_i), .clr_i(clr_i), .irq_en_i(irq_en_i),
  .flags_o(flags_o), .busy_o(busy_o), .irq_o(irq_o)
);

// File: tb/uart_rx_evt_flags_tb.sv
module uart_rx_evt_flags_tb;
  localparam int CNT_W = 10;
  localparam int LEN_W = 8;
  localparam int TO_W  = 16;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_busy = 0, byte_v = 0, sb = 0, bstart = 0, tick = 0, cts_n = 1, brk = 0, clr_we = 0;
  logic [LEN_W-1:0] len = 0;
  logic [TO_W-1:0]  to_val = 0;
  logic [3:0] clr = 0, en = 0;
  logic [3:0] flags;
  logic cts_lvl, busy, irq;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0, cmp_on = 0;

  // reference model state
  int m_cnt, m_tcnt;
  bit m_arm, m_s1, m_s2, m_s3, m_irq, m_busy;
  logic [3:0] m_fl, m_set, m_clr;

  always #2.5 clk = ~clk;

  uart_rx_evt_flags #(.CNT_W(CNT_W), .LEN_W(LEN_W), .TO_W(TO_W)) u_dut (
    .clk(clk), .rst(rst), .rx_busy_i(rx_busy), .byte_i(byte_v), .start_i(sb),
    .blk_start_i(bstart), .blk_len_i(len), .tick_i(tick), .to_val_i(to_val),
    .cts_n_i(cts_n), .brk_i(brk), .clr_we_i(clr_we), .clr_i(clr), .irq_en_i(en),
    .flags_o(flags), .cts_lvl_o(cts_lvl), .busy_o(busy), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      summary();
    end
  end

  // model built from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tcnt = 0; m_arm = 0; m_s1 = 1; m_s2 = 1; m_s3 = 1;
      m_fl = 0; m_irq = 0; m_busy = 0;
    end else begin
      m_set  = 0;
      m_irq  = |(m_fl & en);
      m_busy = rx_busy;
      if (bstart) m_cnt = 0;
      else if (byte_v) begin
        if (m_cnt != CMAX) m_cnt++;
        if (m_cnt >= int'(len) + 4) m_set[0] = 1;
      end
      if (byte_v || sb) begin
        m_tcnt = 0; m_arm = 1;
      end else if (tick && m_arm) begin
        m_tcnt++;
        if (m_tcnt >= int'(to_val)) begin
          m_set[1] = 1; m_arm = 0; m_tcnt = 0;
        end
      end
      m_set[2] = (m_s2 != m_s3);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts_n;
      m_set[3] = brk;
      m_clr = clr_we ? clr : 4'b0;
      m_fl = m_set | (m_fl & ~m_clr);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(flags[0] == m_fl[0], "R2", flags[0], m_fl[0]);
      chk(flags[1] == m_fl[1], "R4", flags[1], m_fl[1]);
      chk(flags[2] == m_fl[2], "R6", flags[2], m_fl[2]);
      chk(flags[3] == m_fl[3], "R7", flags[3], m_fl[3]);
      chk(cts_lvl == !m_s2, "R5", cts_lvl, !m_s2);
      chk(irq == m_irq, "R10", irq, m_irq);
      chk(busy == m_busy, "R11", busy, m_busy);
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic pulse_byte(int n);
    for (int i = 0; i < n; i++) begin byte_v = 1; cyc(); byte_v = 0; end
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk(flags == 4'b0, "R1", flags, 0);
    chk(irq == 0, "R1", irq, 0);
    chk(busy == 0, "R1", busy, 0);
    chk(cts_lvl == 0, "R1", cts_lvl, 0);
    cmp_on = 1;

    // R2 exact threshold: len 2 -> 6 characters
    len = 2; bstart = 1; cyc(); bstart = 0;
    pulse_byte(5);
    chk(flags[0] == 0, "R2", flags[0], 0);
    pulse_byte(1);
    chk(flags[0] == 1, "R2", flags[0], 1);
    // R8: zero bit keeps, one bit clears
    clr_we = 1; clr = 4'b1110; cyc(); clr_we = 0;
    chk(flags[0] == 1, "R8", flags[0], 1);
    clr_we = 1; clr = 4'b0001; cyc(); clr_we = 0;
    chk(flags[0] == 0, "R8", flags[0], 0);
    // R9: set and clear together
    byte_v = 1; clr_we = 1; clr = 4'b0001; cyc(); byte_v = 0; clr_we = 0;
    chk(flags[0] == 1, "R9", flags[0], 1);
    // R2 block start beats strobe
    bstart = 1; byte_v = 1; cyc(); bstart = 0; byte_v = 0;
    clr_we = 1; clr = 4'b0001; cyc(); clr_we = 0;
    pulse_byte(5);
    chk(flags[0] == 0, "R2", flags[0], 0);

    // R3 saturation: len 255 (threshold 259), 1100 strobes
    len = 255; bstart = 1; cyc(); bstart = 0;
    pulse_byte(1100);
    clr_we = 1; clr = 4'b0001; cyc(); clr_we = 0;
    pulse_byte(1);
    chk(flags[0] == 1, "R3", flags[0], 1);

    // R4 timeout 5 ticks, one shot
    to_val = 5; sb = 1; cyc(); sb = 0;
    for (int i = 0; i < 4; i++) begin tick = 1; cyc(); tick = 0; end
    chk(flags[1] == 0, "R4", flags[1], 0);
    tick = 1; cyc(); tick = 0;
    chk(flags[1] == 1, "R4", flags[1], 1);
    clr_we = 1; clr = 4'b0010; cyc(); clr_we = 0;
    for (int i = 0; i < 8; i++) begin tick = 1; cyc(); tick = 0; end
    chk(flags[1] == 0, "R4", flags[1], 0);

    // R5/R6 CTS falling pin
    cts_n = 0; cyc(); cyc();
    chk(cts_lvl == 1, "R5", cts_lvl, 1);
    cyc();
    chk(flags[2] == 1, "R6", flags[2], 1);

    // R7 break, R10 interrupt
    en = 4'b1000; brk = 1; cyc(); brk = 0;
    chk(flags[3] == 1, "R7", flags[3], 1);
    cyc();
    chk(irq == 1, "R10", irq, 1);
    clr_we = 1; clr = 4'b1111; cyc(); clr_we = 0;

    // random phase
    for (int c = 0; c < 6000; c++) begin
      byte_v  = ($urandom % 100) < 20;
      sb      = ($urandom % 100) < 5;
      bstart  = ($urandom % 100) < 2;
      tick    = ($urandom % 100) < 30;
      brk     = ($urandom % 100) < 2;
      clr_we  = ($urandom % 100) < 12;
      clr     = 4'($urandom);
      rx_busy = ($urandom % 100) < 50;
      if (($urandom % 100) < 3) cts_n = ~cts_n;
      if (($urandom % 100) < 2) en = 4'($urandom);
      if (($urandom % 500) == 0) len = LEN_W'($urandom % 12);
      if (($urandom % 500) == 0) to_val = TO_W'($urandom % 16);
      cyc();
    end
    byte_v = 0; sb = 0; bstart = 0; tick = 0; brk = 0; clr_we = 0;
    cyc(); cyc();
    summary();
  end
endmodule